// File: doc/BRIEF.md
# Swapping Bus-Matching Read Unpacker

This block sits on the read side of a FIFO that stores 36-bit long words. It hands those long words out to a port that can be set to long-word, word (18-bit) or byte (9-bit) width. Before a long word is split into narrower pieces, the block reorders its four 9-bit lanes according to a 2-bit swap select. The port therefore sees the data in the byte order it expects, whatever transfer width it uses.

The FIFO is show-ahead: its head long word sits on `fifo_data` while `fifo_empty` is low. The block counts which piece of the head long word is next. It issues `fifo_pop` only in the cycle that takes the final piece. As a result the port-side availability flag stays high until the last piece of the last stored long word has been read.

The swap select is sampled on the first piece of each long word. Later pieces of that long word ignore changes on it.

Top module: `swap_unpacker`

## Requirements
- R1: A read happens on a rising clock edge only when `rd_sel_n` is 0, `rd_write` is 0, `rd_en` is 1 and `port_avail` is 1. In any other cycle `port_dout`, the piece position and the FIFO contents are left unchanged.
- R2: `bus_size` = 2'b11 is reserved. It blocks every read, and `port_dout`, the piece position and the FIFO stay unchanged.
- R3: With `bus_size` = 2'b00 (long), each read places the whole swapped long word on `port_dout[35:0]` and pops the FIFO.
- R4: With `bus_size` = 2'b01 (word), a long word takes two reads. The first read gives swapped bits [35:18] and the second gives swapped bits [17:0]. Each is delivered on `port_dout[17:0]` with the upper bits at zero.
- R5: With `bus_size` = 2'b10 (byte), a long word takes four reads. They give swapped lanes 3, 2, 1, 0 in that order, where lane k is bits [9k+8:9k]. Each lane is delivered on `port_dout[8:0]` with the upper bits at zero.
- R6: Swap codes, with lanes of the swapped word listed from lane 3 down to lane 0 by their source lane:
  - 2'b00 gives 3,2,1,0.
  - 2'b01 gives 0,1,2,3.
  - 2'b10 gives 1,0,3,2.
  - 2'b11 gives 2,3,0,1.
  
  Every swap code works with every size.
- R7: The swap code is taken from `swap_sel` on the first read of a long word. That code is used for all remaining reads of the same long word.
- R8: `fifo_pop` is asserted only on the read that takes the last piece of a long word. `port_avail` (high = data available) therefore drops only after the last piece of the last stored long word has been read.
- R9: Synchronous reset clears `port_dout` to zero and the piece position to the first piece, so the next read starts at the beginning of the head long word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_sel_n | input | 1 | Port select, active low |
| rd_write | input | 1 | Direction select, 1 = write, 0 = read |
| rd_en | input | 1 | Transfer enable, active high |
| bus_size | input | 2 | 00 long, 01 word, 10 byte, 11 reserved |
| swap_sel | input | 2 | Lane reordering code |
| fifo_data | input | 36 | Head long word of the FIFO (show-ahead) |
| fifo_empty | input | 1 | FIFO holds no long word |
| fifo_pop | output | 1 | Remove the head long word |
| port_dout | output | 36 | Registered port read data |
| port_avail | output | 1 | Port empty flag, high when a read can proceed |

## Verification
The hardest case to reach is a long word whose swap select changes between its pieces while blocked cycles are mixed in. In that case the latched code and the held piece position must both survive the stalls. To get there, the stimulus starts a byte-mode long word with one swap code. It then changes `swap_sel` and drives cycles that are deselected, write-direction, disabled and of reserved size. Only after that does it take the remaining lanes. The expected lanes all follow the first code, and the FIFO depth must not change until the fourth lane. A reset applied partway through a long word is also driven, to show that reading restarts at lane 3 of the same head word.

// File: rtl/unpk_pkg.sv
package unpk_pkg;

    localparam int NUM_LANES = 4;
    localparam int CNT_W     = $clog2(NUM_LANES);

    typedef enum logic [1:0] {
        SZ_LONG = 2'b00,
        SZ_WORD = 2'b01,
        SZ_BYTE = 2'b10,
        SZ_RSVD = 2'b11
    } size_e;

    typedef enum logic [1:0] {
        SW_NONE    = 2'b00,
        SW_REVERSE = 2'b01,
        SW_HALVES  = 2'b10,
        SW_INHALF  = 2'b11
    } swap_e;

    typedef struct packed {
        logic [CNT_W-1:0] idx;
        logic             last;
    } lane_pos_t;

    // Source lane of output lane g is g XOR mask.
    function automatic logic [CNT_W-1:0] lane_mask(swap_e m);
        case (m)
            SW_REVERSE: return CNT_W'(3);
            SW_HALVES:  return CNT_W'(2);
            SW_INHALF:  return CNT_W'(1);
            default:    return CNT_W'(0);
        endcase
    endfunction

    function automatic logic [CNT_W-1:0] last_index(size_e s);
        case (s)
            SZ_WORD: return CNT_W'(1);
            SZ_BYTE: return CNT_W'(3);
            default: return CNT_W'(0);
        endcase
    endfunction

endpackage

// File: rtl/unpk_lane_seq.sv
module unpk_lane_seq
    import unpk_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      rd_go,
    input  size_e     size,
    input  swap_e     swap_sel,
    output lane_pos_t pos,
    output swap_e     swap_eff
);

    logic [CNT_W-1:0] cnt_q;
    swap_e            swap_q;

    always_comb begin
        pos.idx  = cnt_q;
        pos.last = (cnt_q >= last_index(size));
        swap_eff = (cnt_q == '0) ? swap_sel : swap_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            swap_q <= SW_NONE;
        end else if (rd_go) begin
            swap_q <= swap_eff;
            cnt_q  <= pos.last ? '0 : cnt_q + 1'b1;
        end
    end

    // R8: a finished long word restarts the piece position
    p_wrap_r8: assert property (@(posedge clk) disable iff (rst)
        (rd_go && pos.last) |=> (cnt_q == '0));

    // R1: no read, no movement of the piece position
    p_hold_pos_r1: assert property (@(posedge clk) disable iff (rst)
        !rd_go |=> $stable(cnt_q));

    // R7: the code seen on the first piece is what gets held
    p_latch_swap_r7: assert property (@(posedge clk) disable iff (rst)
        (rd_go && cnt_q == '0) |=> (swap_q == $past(swap_sel)));

endmodule

// File: rtl/unpk_swap.sv
module unpk_swap
    import unpk_pkg::*;
#(
    parameter int LANE_W = 9,
    localparam int DATA_W = LANE_W * NUM_LANES
)(
    input  logic [DATA_W-1:0] din,
    input  swap_e             mode,
    output logic [DATA_W-1:0] dout
);

    logic [CNT_W-1:0] mask;

    assign mask = lane_mask(mode);

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        logic [CNT_W-1:0] src;
        assign src = CNT_W'(g) ^ mask;
        assign dout[g*LANE_W +: LANE_W] = din[src*LANE_W +: LANE_W];
    end

    // R6: a lane permutation keeps the number of set bits
    always_comb begin
        if (!$isunknown(din) && !$isunknown(mode))
            p_perm_r6: assert ($countones(dout) == $countones(din));
    end

endmodule

// File: rtl/unpk_lane_pick.sv
module unpk_lane_pick
    import unpk_pkg::*;
#(
    parameter int LANE_W = 9,
    localparam int DATA_W = LANE_W * NUM_LANES,
    localparam int HALF_W = DATA_W / 2
)(
    input  logic [DATA_W-1:0] swapped,
    input  size_e             size,
    input  logic [CNT_W-1:0]  idx,
    output logic [DATA_W-1:0] piece
);

    logic [CNT_W-1:0] byte_lane;
    logic             half_sel;

    assign byte_lane = CNT_W'(NUM_LANES - 1) - idx;
    assign half_sel  = ~idx[0];

    always_comb begin
        piece = '0;
        case (size)
            SZ_WORD: piece[HALF_W-1:0] = swapped[half_sel*HALF_W +: HALF_W];
            SZ_BYTE: piece[LANE_W-1:0] = swapped[byte_lane*LANE_W +: LANE_W];
            default: piece = swapped;
        endcase
    end

endmodule

// File: rtl/swap_unpacker.sv
module swap_unpacker
    import unpk_pkg::*;
#(
    parameter int LANE_W = 9,
    localparam int DATA_W = LANE_W * NUM_LANES
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_sel_n,
    input  logic              rd_write,
    input  logic              rd_en,
    input  logic [1:0]        bus_size,
    input  logic [1:0]        swap_sel,
    input  logic [DATA_W-1:0] fifo_data,
    input  logic              fifo_empty,
    output logic              fifo_pop,
    output logic [DATA_W-1:0] port_dout,
    output logic              port_avail
);

    size_e             size;
    swap_e             swap_in;
    swap_e             swap_eff;
    lane_pos_t         pos;
    logic              rd_go;
    logic [DATA_W-1:0] swapped;
    logic [DATA_W-1:0] piece;

    assign size       = size_e'(bus_size);
    assign swap_in    = swap_e'(swap_sel);
    assign port_avail = ~fifo_empty;
    assign rd_go      = ~rd_sel_n & ~rd_write & rd_en & port_avail & (size != SZ_RSVD);
    assign fifo_pop   = rd_go & pos.last;

    unpk_lane_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .rd_go    (rd_go),
        .size     (size),
        .swap_sel (swap_in),
        .pos      (pos),
        .swap_eff (swap_eff)
    );

    unpk_swap #(.LANE_W(LANE_W)) u_swap (
        .din  (fifo_data),
        .mode (swap_eff),
        .dout (swapped)
    );

    unpk_lane_pick #(.LANE_W(LANE_W)) u_pick (
        .swapped (swapped),
        .size    (size),
        .idx     (pos.idx),
        .piece   (piece)
    );

    always_ff @(posedge clk) begin
        if (rst)        port_dout <= '0;
        else if (rd_go) port_dout <= piece;
    end

    // R8: never pop a FIFO that holds nothing
    p_no_pop_empty_r8: assert property (@(posedge clk) disable iff (rst)
        fifo_empty |-> !fifo_pop);

    // R2: reserved size leaves the port data alone
    p_rsvd_blocks_r2: assert property (@(posedge clk) disable iff (rst)
        (bus_size == 2'b11) |=> $stable(port_dout));

    // R1: deselected, write-direction or disabled cycles hold the data
    p_idle_hold_r1: assert property (@(posedge clk) disable iff (rst)
        (rd_sel_n || rd_write || !rd_en) |=> $stable(port_dout));

    // R5: a byte read drives only the low lane
    p_byte_narrow_r5: assert property (@(posedge clk) disable iff (rst)
        (rd_go && bus_size == 2'b10) |=> (port_dout[DATA_W-1:LANE_W] == '0));

    // R3: a long-size read always finishes its long word
    p_long_pops_r3: assert property (@(posedge clk) disable iff (rst)
        (rd_go && bus_size == 2'b00) |-> fifo_pop);

endmodule

// File: tb/tb_swap_unpacker.sv
module tb_swap_unpacker;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        rd_sel_n, rd_write, rd_en;
    logic [1:0]  bus_size, swap_sel;
    logic [35:0] fifo_data;
    logic        fifo_empty;
    logic        fifo_pop;
    logic [35:0] port_dout;
    logic        port_avail;

    logic [35:0] fq[$];
    logic [35:0] exp_val[$];
    string       exp_tag[$];

    int checks = 0;
    int fails  = 0;
    int bcnt   = 0;
    logic [1:0]  bsw = 2'b00;
    logic [35:0] last_exp = '0;
    bit          done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    swap_unpacker dut (
        .clk(clk), .rst(rst), .rd_sel_n(rd_sel_n), .rd_write(rd_write),
        .rd_en(rd_en), .bus_size(bus_size), .swap_sel(swap_sel),
        .fifo_data(fifo_data), .fifo_empty(fifo_empty), .fifo_pop(fifo_pop),
        .port_dout(port_dout), .port_avail(port_avail)
    );

    // Show-ahead FIFO model
    always_comb begin
        fifo_empty = (fq.size() == 0);
        fifo_data  = fifo_empty ? 36'h0 : fq[0];
    end
    always @(posedge clk) if (fifo_pop && fq.size() > 0) void'(fq.pop_front());

    task automatic chk(input bit ok, input string tag, input logic [35:0] act, input logic [35:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [35:0] swp(input logic [35:0] w, input logic [1:0] m);
        case (m)
            2'b01:   return {w[8:0], w[17:9], w[26:18], w[35:27]};
            2'b10:   return {w[17:9], w[8:0], w[35:27], w[26:18]};
            2'b11:   return {w[26:18], w[35:27], w[8:0], w[17:9]};
            default: return w;
        endcase
    endfunction

    // Driver: one cycle of port activity, expectation pushed to the scoreboard
    task automatic step(input logic sel_n, input logic wr, input logic en,
                        input logic [1:0] sz, input logic [1:0] sw, input string tag);
        logic [35:0] s;
        logic [1:0]  eff;
        int          n;
        @(negedge clk);
        rd_sel_n = sel_n; rd_write = wr; rd_en = en; bus_size = sz; swap_sel = sw;
        if (!sel_n && !wr && en && sz != 2'b11 && fq.size() != 0) begin
            eff = (bcnt == 0) ? sw : bsw;
            bsw = eff;
            s = swp(fq[0], eff);
            case (sz)
                2'b00: begin last_exp = s; n = 1; end
                2'b01: begin last_exp = {18'h0, (bcnt == 0) ? s[35:18] : s[17:0]}; n = 2; end
                default: begin last_exp = {27'h0, s[(3-bcnt)*9 +: 9]}; n = 4; end
            endcase
            bcnt = (bcnt + 1 == n) ? 0 : bcnt + 1;
        end
        exp_val.push_back(last_exp);
        exp_tag.push_back(tag);
        @(posedge clk); #2;
    endtask

    // Monitor
    always @(posedge clk) begin
        #1;
        if (exp_val.size() > 0) begin
            logic [35:0] e;
            string       t;
            e = exp_val.pop_front();
            t = exp_tag.pop_front();
            chk(port_dout === e, t, port_dout, e);
        end
    end

    task automatic idle();
        @(negedge clk);
        rd_sel_n = 1'b1; rd_write = 1'b0; rd_en = 1'b0; bus_size = 2'b00; swap_sel = 2'b00;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        bcnt = 0; bsw = 2'b00; last_exp = '0;
        @(posedge clk); #2;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        fails++;
        $display("FAIL watchdog: actual %h expected %h", 36'h1, 36'h0);
        finish_run();
    end

    initial begin
        int depth;
        rst = 1'b1; rd_sel_n = 1'b1; rd_write = 1'b0; rd_en = 1'b0;
        bus_size = 2'b00; swap_sel = 2'b00;
        do_reset();
        chk(port_dout === 36'h0, "R9 reset data", port_dout, 36'h0);
        chk(port_avail === 1'b0, "R8 empty after reset", {35'h0, port_avail}, 36'h0);

        // R1: read attempt on empty FIFO
        step(0, 0, 1, 2'b10, 2'b00, "R1 read while empty");

        // R3 + R6: long size, every swap code
        fq.push_back(36'h123456789); fq.push_back(36'hABCDEF012);
        fq.push_back(36'h3C5A69F0E); fq.push_back(36'h987654321);
        step(0, 0, 1, 2'b00, 2'b00, "R3 R6 long none");
        step(0, 0, 1, 2'b00, 2'b01, "R3 R6 long reverse");
        step(0, 0, 1, 2'b00, 2'b10, "R3 R6 long halves");
        step(0, 0, 1, 2'b00, 2'b11, "R3 R6 long in-half");
        chk(fq.size() == 0, "R3 one pop per long read", 36'(fq.size()), 36'h0);

        // R4 + R8: word size, avail stays high mid-word
        fq.push_back(36'hF0E1D2C3B); fq.push_back(36'h0A1B2C3D4);
        step(0, 0, 1, 2'b01, 2'b01, "R4 word hi reverse");
        chk(fq.size() == 2, "R8 no pop mid-word", 36'(fq.size()), 36'h2);
        step(0, 0, 1, 2'b01, 2'b00, "R4 word lo");
        step(0, 0, 1, 2'b01, 2'b11, "R4 word hi in-half");
        chk(port_avail === 1'b1, "R8 avail before final half", {35'h0, port_avail}, 36'h1);
        step(0, 0, 1, 2'b01, 2'b11, "R4 word lo in-half");
        chk(port_avail === 1'b0, "R8 avail drops after final half", {35'h0, port_avail}, 36'h0);

        // R5 + R7 + R1 + R2: byte size, swap changes and blocked cycles mid-word
        fq.push_back(36'h1F2E3D4C5);
        step(0, 0, 1, 2'b10, 2'b01, "R5 R7 byte lane3");
        step(1, 0, 1, 2'b10, 2'b10, "R1 deselected");
        step(0, 1, 1, 2'b10, 2'b10, "R1 write direction");
        step(0, 0, 0, 2'b10, 2'b10, "R1 disabled");
        step(0, 0, 1, 2'b11, 2'b10, "R2 reserved size");
        chk(fq.size() == 1, "R2 no pop when blocked", 36'(fq.size()), 36'h1);
        step(0, 0, 1, 2'b10, 2'b10, "R5 R7 byte lane2");
        step(0, 0, 1, 2'b10, 2'b11, "R5 R7 byte lane1");
        chk(port_avail === 1'b1, "R8 avail before fourth byte", {35'h0, port_avail}, 36'h1);
        step(0, 0, 1, 2'b10, 2'b00, "R5 R7 byte lane0");
        chk(port_avail === 1'b0, "R8 avail drops after fourth byte", {35'h0, port_avail}, 36'h0);

        // R6 with byte size, in-half code
        fq.push_back(36'h5A5A0F0F3);
        for (int k = 0; k < 4; k++) step(0, 0, 1, 2'b10, 2'b11, "R6 byte in-half");

        // R9: reset partway through a long word restarts at lane 3
        fq.push_back(36'h246813579);
        step(0, 0, 1, 2'b10, 2'b00, "R5 byte before reset");
        step(0, 0, 1, 2'b10, 2'b00, "R5 byte before reset");
        idle();
        do_reset();
        chk(port_dout === 36'h0, "R9 data cleared", port_dout, 36'h0);
        depth = fq.size();
        chk(depth == 1, "R9 head word kept", 36'(depth), 36'h1);
        step(0, 0, 1, 2'b10, 2'b00, "R9 restart lane3");
        step(0, 0, 1, 2'b10, 2'b00, "R9 lane2");
        step(0, 0, 1, 2'b10, 2'b00, "R9 lane1");
        step(0, 0, 1, 2'b10, 2'b00, "R9 lane0");
        chk(fq.size() == 0, "R8 popped after fourth", 36'(fq.size()), 36'h0);

        idle();
        repeat (3) @(posedge clk);
        #3;
        finish_run();
    end

endmodule